// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM organised as 256K words of 8 bits. The host presents an address, write data and a read/write select together with a valid strobe. The controller accepts the request only while it is idle. It then sequences the memory's active-low chip-select, output-enable and write-strobe pins, and it drives the shared data bus through a separate tristate enable. When the access is finished it returns a single-cycle completion pulse. For a read, the byte returned by the memory is held in a register until the next read finishes.

Every memory timing minimum is a parameter in nanoseconds, as is the clock period. Each minimum is rounded up to a whole number of clock cycles, and any nonzero minimum gets at least one cycle. During a write the output enable stays high, so the shorter write-strobe minimum applies. The data drivers turn on only after the memory has had time to release the bus following the fall of the write strobe. When the direction of traffic changes between accesses, one extra idle cycle lets the bus turn around.

Top module: `sramc_top`

## Requirements
- R1: While reset is low and just after it, memCeN, memOeN and memWeN are 1, memDqOe is 0, reqReady is 1 and done is 0.
- R2: reqReady is 1 only in the idle state. A request is taken only on a clock edge where reqValid and reqReady are both 1. Valid requests presented while busy are ignored: no further chip-select activity follows completion.
- R3: A read holds memCeN=0, memOeN=0 and memWeN=1 for ceil(max(tRC,tAA)/clock) cycles, at least one. The bus byte is then captured into rdData. With the 10 ns defaults, done is seen 2 cycles after the accepting edge.
- R4: done is 1 for exactly one cycle per accepted request and is never high on two consecutive cycles.
- R5: memOeN is 1 in every cycle in which memWeN is 0.
- R6: memDqOe stays 0 for at least the float-time cycle count after memWeN falls. It remains 1 through the cycle after memWeN rises.
- R7: A write holds memWeN low long enough to meet the write-pulse minimum. The driven byte is stable for at least the data-setup minimum before memWeN rises. With the defaults, done is seen 4 cycles after the accepting edge.
- R8: memAddr does not change while memCeN stays 0 across consecutive cycles.
- R9: When a read follows a write, or a write follows a read, one extra cycle with memCeN=1 and memOeN=1 is inserted. Completion then comes one cycle later than for a same-direction access.
- R10: rdData changes only when a read completes and keeps its value across writes.
- R11: The controller never enables its drivers while the memory drives the bus (memCeN=0, memWeN=1, memOeN=0) or in the cycle after it stopped doing so.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 8 | Byte to write |
| reqReady | output | 1 | Controller idle, request may be taken |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Last byte read |
| memAddr | output | 18 | Memory address lines |
| memCeN | output | 1 | Memory chip select, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memDqOut | output | 8 | Byte driven onto the data bus |
| memDqOe | output | 1 | Tristate enable for memDqOut |
| memDqIn | input | 8 | Byte sampled from the data bus |

## Verification
The embedded properties assume the host keeps reqWrite, reqAddr and reqWdata steady while reqValid is high. They also assume memDqIn is a settled value whenever a read is captured. The bench changes request fields and the valid strobe only at falling clock edges. Its memory model returns a defined byte while it drives the bus and zero otherwise. The model also checks strobe widths, setup windows and bus ownership sample by sample.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic drive;
    logic capture;
    logic load;
  } memStrobes_t;

  function automatic int nsToCycles(input int ns, input int clkNs);
    if (ns <= 0) return 0;
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int T_RC   = 10,
  parameter int T_AA   = 10,
  parameter int T_WC   = 10,
  parameter int T_AW   = 8,
  parameter int T_PWE  = 7,
  parameter int T_SD   = 5,
  parameter int T_HZWE = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output logic        done,
  output memStrobes_t strb
);

  localparam int RD_CYC  = maxOf(1, maxOf(nsToCycles(T_RC, CLK_NS), nsToCycles(T_AA, CLK_NS)));
  localparam int FLT_CYC = maxOf(1, nsToCycles(T_HZWE, CLK_NS));
  localparam int DRV_CYC = maxOf(1, maxOf(nsToCycles(T_SD, CLK_NS),
                             maxOf(nsToCycles(T_PWE, CLK_NS) - FLT_CYC,
                                   nsToCycles(T_AW, CLK_NS) - FLT_CYC)));
  localparam int END_CYC = maxOf(1, nsToCycles(T_WC, CLK_NS) - FLT_CYC - DRV_CYC);
  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, FLT_CYC), maxOf(DRV_CYC, END_CYC));
  localparam int CNT_W   = maxOf(1, $clog2(MAX_CYC + 1));

  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] FLT_LD = CNT_W'(FLT_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_LD = CNT_W'(DRV_CYC - 1);
  localparam logic [CNT_W-1:0] END_LD = CNT_W'(END_CYC - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_READ, ST_WFLOAT, ST_WDRIVE, ST_WEND, ST_DONE
  } ctrlState_t;

  ctrlState_t       state;
  logic [CNT_W-1:0] cnt;
  logic             curWrite;
  logic             prevValid;
  logic             cntZero;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      curWrite  <= 1'b0;
      prevValid <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          curWrite  <= reqWrite;
          prevValid <= 1'b1;
          if (prevValid && (curWrite != reqWrite)) begin
            state <= ST_TURN;
          end else begin
            state <= reqWrite ? ST_WFLOAT : ST_READ;
            cnt   <= reqWrite ? FLT_LD : RD_LD;
          end
        end
        ST_TURN: begin
          state <= curWrite ? ST_WFLOAT : ST_READ;
          cnt   <= curWrite ? FLT_LD : RD_LD;
        end
        ST_READ:   if (cntZero) state <= ST_DONE;
                   else cnt <= cnt - 1'b1;
        ST_WFLOAT: if (cntZero) begin state <= ST_WDRIVE; cnt <= DRV_LD; end
                   else cnt <= cnt - 1'b1;
        ST_WDRIVE: if (cntZero) begin state <= ST_WEND; cnt <= END_LD; end
                   else cnt <= cnt - 1'b1;
        ST_WEND:   if (cntZero) state <= ST_DONE;
                   else cnt <= cnt - 1'b1;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb = '{ceN: 1'b1, oeN: 1'b1, weN: 1'b1, drive: 1'b0, capture: 1'b0, load: 1'b0};
    case (state)
      ST_IDLE:   strb.load = reqValid;
      ST_READ:   begin strb.ceN = 1'b0; strb.oeN = 1'b0; strb.capture = cntZero; end
      ST_WFLOAT: begin strb.ceN = 1'b0; strb.weN = 1'b0; end
      ST_WDRIVE: begin strb.ceN = 1'b0; strb.weN = 1'b0; strb.drive = 1'b1; end
      ST_WEND:   begin strb.ceN = 1'b0; strb.drive = 1'b1; end
      default:   ;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign done     = (state == ST_DONE);

  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !strb.weN |-> strb.oeN); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R4
  AST_DRIVE_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.drive) |-> (!strb.weN && $past(!strb.weN))); // R6
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    strb.drive |-> strb.oeN); // R11
  AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.weN) && !strb.ceN |-> strb.drive); // R6
  AST_READY_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (strb.ceN && !strb.drive)); // R2

endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobes_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rdReg    <= '0;
    end else begin
      if (strb.load) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (strb.capture) rdReg <= memDqIn;
    end
  end

  assign memAddr  = addrReg;
  assign memDqOut = wdataReg;
  assign rdData   = rdReg;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ceN && $past(!strb.ceN)) |-> $stable(memAddr)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.capture) |-> $stable(rdData)); // R10
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.drive && $past(strb.drive)) |-> $stable(memDqOut)); // R7

endmodule

// File: rtl/sramc_top.sv
module sramc_top
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 10,
  parameter int T_RC   = 10,
  parameter int T_AA   = 10,
  parameter int T_WC   = 10,
  parameter int T_AW   = 8,
  parameter int T_PWE  = 7,
  parameter int T_SD   = 5,
  parameter int T_HZWE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  memStrobes_t strb;

  sramc_ctrl #(
    .CLK_NS(CLK_NS), .T_RC(T_RC), .T_AA(T_AA), .T_WC(T_WC),
    .T_AW(T_AW), .T_PWE(T_PWE), .T_SD(T_SD), .T_HZWE(T_HZWE)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .done     (done),
    .strb     (strb)
  );

  sramc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDqIn  (memDqIn),
    .memAddr  (memAddr),
    .memDqOut (memDqOut),
    .rdData   (rdData)
  );

  assign memCeN  = strb.ceN;
  assign memOeN  = strb.oeN;
  assign memWeN  = strb.weN;
  assign memDqOe = strb.drive;

endmodule

// File: tb/test_sramc_top.sv
module test_sramc_top;

  localparam int CLK_NS = 10;
  localparam int NOPS   = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, done;
  logic [7:0]  rdData;
  logic [17:0] memAddr;
  logic        memCeN, memOeN, memWeN, memDqOe;
  logic [7:0]  memDqOut, memDqIn;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sramc_top i_sramc_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady), .done(done),
    .rdData(rdData), .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN),
    .memWeN(memWeN), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // memory model and expectation array (separate)
  logic [7:0] model  [0:255];
  logic [7:0] expMem [0:255];
  logic       memDrives;

  assign memDrives = !memCeN && memWeN && !memOeN;
  assign memDqIn   = memDrives ? model[memAddr[7:0]] : 8'h00;

  int   vR5 = 0, vR6 = 0, vR7 = 0, vR8 = 0, vR11 = 0;
  int   weLowCnt = 0, stableCnt = 0;
  logic prevSel = 1'b0, prevDrove = 1'b0, prevWeN = 1'b1, prevCeN = 1'b1;
  logic [7:0]  lastDrv = '0;
  logic [17:0] prevAddr = '0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      model[i]  = 8'(i) ^ 8'h5A;
      expMem[i] = 8'(i) ^ 8'h5A;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (memDqOe && (memDrives || prevDrove)) vR11++;
      if (!memWeN && !memOeN) vR5++;
      if (memDqOe && !memWeN && prevWeN) vR6++;
      if (!memCeN && !prevCeN && memAddr != prevAddr) vR8++;
      if (!memCeN && !memWeN) begin
        weLowCnt++;
        if (memDqOe && stableCnt > 0 && memDqOut == lastDrv) stableCnt++;
        else stableCnt = memDqOe ? 1 : 0;
      end else if (prevSel) begin
        if (weLowCnt * CLK_NS < 7) vR7++;
        if (stableCnt * CLK_NS < 5) vR7++;
        if (!memDqOe || memDqOut != lastDrv) vR6++;
        model[prevAddr[7:0]] = lastDrv;
        weLowCnt  = 0;
        stableCnt = 0;
      end
      prevSel   = !memCeN && !memWeN;
      prevDrove = memDrives;
      prevWeN   = memWeN;
      prevCeN   = memCeN;
      prevAddr  = memAddr;
      lastDrv   = memDqOut;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // issue one request, return negedges from issue to done
  task automatic doOp(input logic wr, input logic [17:0] a, input logic [7:0] d,
                      output int lat);
    @(negedge clk);
    check("R2 ready before issue", int'(reqReady), 1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) reqValid = 1'b0;
    end while (!done && lat < 50);
    if (lat >= 50) check("R4 done timeout", 0, 1);
    @(negedge clk);
    check("R4 done one cycle", int'(done), 0);
  endtask

  // {write, addr, data}
  localparam logic [26:0] OPS [NOPS] = '{
    {1'b1, 18'h00011, 8'hA1}, {1'b1, 18'h3FF22, 8'hB2},
    {1'b0, 18'h00011, 8'h00}, {1'b0, 18'h3FF22, 8'h00},
    {1'b1, 18'h20033, 8'hC3}, {1'b1, 18'h00011, 8'h44},
    {1'b0, 18'h00011, 8'h00}, {1'b0, 18'h00050, 8'h00},
    {1'b1, 18'h0FF00, 8'h9E}, {1'b0, 18'h0FF00, 8'h00}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    int expLat;
    logic havePrev;
    logic prevWr;
    logic [7:0] heldRd;
    int ceLow;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ceN", int'(memCeN), 1);
    check("R1 oeN", int'(memOeN), 1);
    check("R1 weN", int'(memWeN), 1);
    check("R1 dqOe", int'(memDqOe), 0);
    check("R1 done", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(reqReady), 1);

    havePrev = 1'b0;
    prevWr   = 1'b0;
    for (int k = 0; k < NOPS; k++) begin
      logic        wr;
      logic [17:0] a;
      logic [7:0]  d;
      {wr, a, d} = OPS[k];
      doOp(wr, a, d, lat);
      expLat = wr ? 4 : 2;                       // R3 R7
      if (havePrev && prevWr != wr) expLat++;    // R9
      check(wr ? "R7 R9 write latency" : "R3 R9 read latency", lat, expLat);
      if (wr) expMem[a[7:0]] = d;
      else    check("R3 read data", int'(rdData), int'(expMem[a[7:0]]));
      havePrev = 1'b1;
      prevWr   = wr;
    end

    // R10: write after a read leaves rdData; R2: request while busy ignored
    heldRd = rdData;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 18'h00077; reqWdata = 8'h3C;
    @(negedge clk);
    reqWrite = 1'b0; reqAddr = 18'h00088;   // busy: must not be taken
    lat = 1;
    while (!done && lat < 50) begin @(negedge clk); lat++; end
    reqValid = 1'b0;
    expMem[8'h77] = 8'h3C;
    check("R10 rdData kept across write", int'(rdData), int'(heldRd));
    ceLow = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (!memCeN) ceLow++;
    end
    check("R2 busy request ignored", ceLow, 0);
    check("R2 ready after ignore", int'(reqReady), 1);

    doOp(1'b0, 18'h00077, 8'h00, lat);
    check("R9 read after write latency", lat, 3);
    check("R3 read back", int'(rdData), int'(expMem[8'h77]));

    check("R5 OE high during write", vR5, 0);
    check("R6 driver timing", vR6, 0);
    check("R7 strobe and setup", vR7, 0);
    check("R8 address stable", vR8, 0);
    check("R11 no contention", vR11, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule